// File: doc/BRIEF.md
# Supply and Backup-Battery Supervisor

This block watches the main supply and the backup cell through digital comparator outputs. It drives an open-drain reset line and keeps the battery-low bit of a shared flags byte. A slow timebase tick paces all of its timing. The reset line is pulled low at once when the supply drops below its trip point. After the supply comes back, the line stays low until the supply has stayed above its upper detect level for a programmable number of ticks.

The backup cell is sampled at two kinds of moment. The first is once in every power-up sequence, in the last cycle before reset is released. The second is every `INTERVAL_TICKS` ticks after that, and only while the supply is good. The stored flag keeps its value between samples. The flags byte is owned outside this block, so the block only supplies the value for its battery-low bit position.

States and transitions (state names as in the RTL):
- `PS_DOWN`
  - Reset pulled.
  - Goes to `PS_AWAIT_MAX` when the trip comparator clears.
- `PS_AWAIT_MAX`
  - Reset pulled.
  - Goes to `PS_RECOVER` when the upper-level comparator is high.
- `PS_RECOVER`
  - Reset pulled; counts ticks.
  - Goes back to `PS_AWAIT_MAX` if the upper level is lost.
  - Goes to `PS_BOOT_CHECK` on tick number `TREC_TICKS`.
- `PS_BOOT_CHECK`
  - Reset pulled for this one cycle while the cell is sampled.
  - Goes to `PS_ACTIVE`, or to `PS_AWAIT_MAX` if the upper level is lost.
- `PS_ACTIVE`
  - Reset released; counts ticks.
  - Goes to `PS_SCHED_CHECK` on tick number `INTERVAL_TICKS`.
- `PS_SCHED_CHECK`
  - Reset released.
  - Samples the cell and returns to `PS_ACTIVE` once the upper level is high; waits otherwise.

A trip from any state goes to `PS_DOWN` and takes priority over every other transition.

Top module: `pwr_supervisor`

## Requirements
- R1: Whenever `supply_low` is 1, `rst_pd_en` is 1 in that same cycle, whatever the state.
- R2: While `rst_n` is low, `rst_pd_en` is 1, `bl_flag` is 0, `bl_upd` is 0 and `flags_bl_field` is 0.
- R3: `rst_pd_en` falls only at the clock edge after the boot-check cycle. That cycle follows the edge that captured the `TREC_TICKS`-th tick counted in `PS_RECOVER`.
- R4: If `supply_ok` drops during `PS_RECOVER` while `supply_low` is 0, the next state is `PS_AWAIT_MAX`, and the recovery count restarts from zero on re-entry.
- R5: In the boot-check cycle with `supply_ok`=1 and `supply_low`=0, `batt_low` is captured. It appears on `bl_flag` after the next edge, together with a one-cycle `bl_upd`=1.
- R6: In `PS_ACTIVE`, the `INTERVAL_TICKS`-th tick leads to a scheduled check. That check captures `batt_low` in the same way as R5.
- R7: A scheduled check with `supply_ok`=0 takes no sample and leaves `bl_flag` unchanged. It waits, then samples in the first cycle with `supply_ok`=1.
- R8: A `supply_low` of 1 during a check cycle aborts that check: `bl_flag` is unchanged and `bl_upd` stays 0.
- R9: `bl_flag` changes only together with `bl_upd`=1. A change of `batt_low` between checks has no effect on it.
- R10: `flags_bl_field` carries `bl_flag` at bit 4 (parameter `BL_BIT`), and every other bit of it is 0.
- R11: The interval count restarts from zero at each power-up. The first scheduled check comes `INTERVAL_TICKS` ticks after entry to `PS_ACTIVE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low | input | 1 | Supply at or below the trip point |
| supply_ok | input | 1 | Supply above its upper detect level |
| batt_low | input | 1 | Backup cell below its threshold |
| tick | input | 1 | One-cycle timebase pulse |
| rst_pd_en | output | 1 | 1 enables the open-drain pull-down, so the reset line reads low |
| bl_flag | output | 1 | Stored battery-low result |
| bl_upd | output | 1 | One-cycle pulse when `bl_flag` was just written |
| flags_bl_field | output | 8 | Flags-byte contribution with `bl_flag` at `BL_BIT` |

## Verification
Several rules are checked by the in-RTL properties on every cycle:
- the combinational pull of reset on a trip;
- the release of reset only out of the boot check;
- the fall-back to `PS_AWAIT_MAX` when the upper level is lost in recovery;
- the flag moving only with an update pulse;
- updates happening only after a cycle of good supply;
- the counter staying in range.

Other behaviour needs the bench's scenarios, which compare against its reference model on every clock. This covers the exact recovery length in ticks, the interval spacing measured from each power-up, a deferred check waiting out a supply sag, and a check aborted by a trip in its own cycle.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic [2:0] {
        PS_DOWN        = 3'd0,
        PS_AWAIT_MAX   = 3'd1,
        PS_RECOVER     = 3'd2,
        PS_BOOT_CHECK  = 3'd3,
        PS_ACTIVE      = 3'd4,
        PS_SCHED_CHECK = 3'd5
    } pwrsup_state_e;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/pwrsup_tickcnt.sv
module pwrsup_tickcnt #(
    parameter int unsigned CW   = 8,
    parameter int unsigned MAXV = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6 / R11: the tick count never runs past the longest terminal value
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt) < MAXV));

endmodule

// File: rtl/pwrsup_bflag.sv
module pwrsup_bflag #(
    parameter int unsigned BL_BIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       din,
    output logic       flag,
    output logic       upd,
    output logic [7:0] field
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            upd  <= 1'b0;
        end else begin
            upd <= load;
            if (load) begin
                flag <= din;
            end
        end
    end

    for (genvar gi = 0; gi < 8; gi++) begin : g_field
        if (gi == BL_BIT) begin : g_bl
            assign field[gi] = flag;
        end else begin : g_zero
            assign field[gi] = 1'b0;
        end
    end

    // R9: the stored result moves only in a cycle flagged as an update
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> (flag == $past(flag)));

endmodule

// File: rtl/pwrsup_fsm.sv
module pwrsup_fsm
    import pwrsup_pkg::*;
#(
    parameter int unsigned TREC_TICKS     = 100,
    parameter int unsigned INTERVAL_TICKS = 86400,
    parameter int unsigned CW             = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_low,
    input  logic          supply_ok,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          bat_load,
    output logic          rst_pd_en
);

    localparam logic [CW-1:0] TREC_LAST = CW'(TREC_TICKS - 1);
    localparam logic [CW-1:0] INTV_LAST = CW'(INTERVAL_TICKS - 1);

    pwrsup_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_DOWN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (supply_low) begin
            state_nx = PS_DOWN;
        end else begin
            unique case (state)
                PS_DOWN:        state_nx = PS_AWAIT_MAX;
                PS_AWAIT_MAX:   if (supply_ok) state_nx = PS_RECOVER;
                PS_RECOVER: begin
                    if (!supply_ok)                      state_nx = PS_AWAIT_MAX;
                    else if (tick && cnt == TREC_LAST)   state_nx = PS_BOOT_CHECK;
                end
                PS_BOOT_CHECK:  state_nx = supply_ok ? PS_ACTIVE : PS_AWAIT_MAX;
                PS_ACTIVE:      if (tick && cnt == INTV_LAST) state_nx = PS_SCHED_CHECK;
                PS_SCHED_CHECK: if (supply_ok) state_nx = PS_ACTIVE;
                default:        state_nx = PS_DOWN;
            endcase
        end
    end

    always_comb begin
        rst_pd_en = 1'b1;
        bat_load  = 1'b0;
        cnt_inc   = 1'b0;
        cnt_clr   = (state_nx != state);
        unique case (state)
            PS_DOWN, PS_AWAIT_MAX: ;
            PS_RECOVER:     cnt_inc = tick;
            PS_BOOT_CHECK:  bat_load = supply_ok && !supply_low;
            PS_ACTIVE: begin
                rst_pd_en = 1'b0;
                cnt_inc   = tick;
            end
            PS_SCHED_CHECK: begin
                rst_pd_en = 1'b0;
                bat_load  = supply_ok && !supply_low;
            end
            default: ;
        endcase
        if (supply_low) begin
            rst_pd_en = 1'b1;
        end
    end

    // R1: a trip pulls the reset line in the same cycle
    a_r1_trip_pulls_reset: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> rst_pd_en);

    // R3: release happens only out of the boot-check cycle
    a_r3_release_after_boot_check: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pd_en) |-> ($past(state) == PS_BOOT_CHECK));

    // R4: losing the upper level in recovery falls back to waiting
    a_r4_recover_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RECOVER && !supply_ok && !supply_low) |=> (state == PS_AWAIT_MAX));

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwrsup_pkg::*;
#(
    parameter int unsigned TREC_TICKS     = 100,
    parameter int unsigned INTERVAL_TICKS = 86400,
    parameter int unsigned BL_BIT         = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_low,
    input  logic       supply_ok,
    input  logic       batt_low,
    input  logic       tick,
    output logic       rst_pd_en,
    output logic       bl_flag,
    output logic       bl_upd,
    output logic [7:0] flags_bl_field
);

    localparam int unsigned CW   = cnt_width(TREC_TICKS, INTERVAL_TICKS);
    localparam int unsigned MAXV = (TREC_TICKS > INTERVAL_TICKS) ? TREC_TICKS : INTERVAL_TICKS;

    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          bat_load;

    pwrsup_fsm #(
        .TREC_TICKS    (TREC_TICKS),
        .INTERVAL_TICKS(INTERVAL_TICKS),
        .CW            (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_low(supply_low),
        .supply_ok (supply_ok),
        .tick      (tick),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .bat_load  (bat_load),
        .rst_pd_en (rst_pd_en)
    );

    pwrsup_tickcnt #(
        .CW  (CW),
        .MAXV(MAXV)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt)
    );

    pwrsup_bflag #(
        .BL_BIT(BL_BIT)
    ) u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .load (bat_load),
        .din  (batt_low),
        .flag (bl_flag),
        .upd  (bl_upd),
        .field(flags_bl_field)
    );

    // R8 / R7: an update always follows a cycle of good, untripped supply
    a_r8_update_needs_good_supply: assert property (@(posedge clk) disable iff (!rst_n)
        bl_upd |-> ($past(supply_ok) && !$past(supply_low)));

endmodule

// File: tb/sim_pwr_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_supervisor;

    localparam int TR = 6;
    localparam int IV = 20;

    localparam int M_DOWN = 0, M_WAIT = 1, M_REC = 2, M_BOOT = 3, M_RUN = 4, M_SCHED = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b1;
    logic supply_ok = 1'b0;
    logic batt_low = 1'b0;
    logic tick = 1'b0;
    logic rst_pd_en, bl_flag, bl_upd;
    logic [7:0] flags_bl_field;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int tdiv = 0;

    int  m_phase = M_DOWN;
    int  m_cnt = 0;
    bit  m_bl = 0;
    bit  m_upd = 0;

    always #2.5 clk = ~clk;

    pwr_supervisor #(.TREC_TICKS(TR), .INTERVAL_TICKS(IV), .BL_BIT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .supply_ok(supply_ok),
        .batt_low(batt_low), .tick(tick), .rst_pd_en(rst_pd_en), .bl_flag(bl_flag),
        .bl_upd(bl_upd), .flags_bl_field(flags_bl_field)
    );

    always @(negedge clk) begin
        tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
        tick <= (tdiv == 2);
    end

    // reference model, evaluated on pre-edge inputs
    always @(posedge clk) begin
        cyc = cyc + 1;
        m_upd = 0;
        if (!rst_n) begin
            m_phase = M_DOWN; m_cnt = 0; m_bl = 0;
        end else if (supply_low) begin
            m_phase = M_DOWN;
        end else begin
            case (m_phase)
                M_DOWN: m_phase = M_WAIT;
                M_WAIT: if (supply_ok) begin m_phase = M_REC; m_cnt = 0; end
                M_REC: begin
                    if (!supply_ok) m_phase = M_WAIT;
                    else if (tick) begin
                        if (m_cnt == TR - 1) m_phase = M_BOOT;
                        else m_cnt = m_cnt + 1;
                    end
                end
                M_BOOT: begin
                    if (supply_ok) begin m_bl = batt_low; m_upd = 1; m_phase = M_RUN; m_cnt = 0; end
                    else m_phase = M_WAIT;
                end
                M_RUN: if (tick) begin
                    if (m_cnt == IV - 1) m_phase = M_SCHED;
                    else m_cnt = m_cnt + 1;
                end
                M_SCHED: if (supply_ok) begin m_bl = batt_low; m_upd = 1; m_phase = M_RUN; m_cnt = 0; end
                default: m_phase = M_DOWN;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // per-cycle comparison, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        chk(rst_pd_en == (supply_low || !(m_phase == M_RUN || m_phase == M_SCHED)),
            "R1 R3 R4 rst_pd_en", rst_pd_en,
            int'(supply_low || !(m_phase == M_RUN || m_phase == M_SCHED)));
        chk(bl_flag == m_bl, "R5 R6 R7 R8 R9 R11 bl_flag", bl_flag, m_bl);
        chk(bl_upd == m_upd, "R5 R6 R8 bl_upd", bl_upd, m_upd);
        chk(flags_bl_field == (8'(m_bl) << 4), "R10 flags_bl_field", flags_bl_field, 8'(m_bl) << 4);
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic spot(input bit ok, input string tag, input int act, input int exp);
        @(posedge clk); #1;
        chk(ok, tag, act, exp);
    endtask

    initial begin
        cycles(3);
        spot(rst_pd_en === 1'b1 && bl_flag === 1'b0 && flags_bl_field === 8'h00 && bl_upd === 1'b0,
             "R2 reset state", {rst_pd_en, bl_flag, bl_upd}, 3'b100);
        @(negedge clk); rst_n = 1'b1;
        cycles(4); supply_low = 1'b0;
        cycles(5); supply_ok = 1'b1;
        cycles(8); supply_ok = 1'b0;          // R4 sag during recovery
        cycles(2); supply_ok = 1'b1;
        cycles(40);
        spot(rst_pd_en == 1'b0 && bl_flag == 1'b0, "R3 R5 released, flag clear",
             {rst_pd_en, bl_flag}, 0);
        @(negedge clk); batt_low = 1'b1;      // R9 between checks
        cycles(10);
        spot(bl_flag == 1'b0, "R9 no update between checks", bl_flag, 0);
        cycles(70);
        spot(bl_flag == 1'b1, "R6 scheduled check", bl_flag, 1);
        @(negedge clk); batt_low = 1'b0;
        wait (m_phase == M_RUN && m_cnt == IV - 1 && tick);
        @(negedge clk); supply_ok = 1'b0;     // R7 defer
        cycles(30);
        spot(bl_flag == 1'b1 && rst_pd_en == 1'b0, "R7 deferred check", bl_flag, 1);
        @(negedge clk); supply_ok = 1'b1;
        cycles(3);
        spot(bl_flag == 1'b0, "R7 check after recovery", bl_flag, 0);
        @(negedge clk); supply_low = 1'b1;    // R1 trip
        #1;
        chk(rst_pd_en == 1'b1, "R1 immediate pull", rst_pd_en, 1);
        cycles(5); supply_low = 1'b0; batt_low = 1'b1;
        wait (m_phase == M_BOOT);
        @(negedge clk); supply_low = 1'b1;    // R8 abort boot check
        cycles(2);
        spot(bl_flag == 1'b0 && bl_upd == 1'b0, "R8 aborted check", bl_flag, 0);
        @(negedge clk); supply_low = 1'b0;
        cycles(40);
        spot(bl_flag == 1'b1, "R5 boot check captures low cell", bl_flag, 1);
        spot(flags_bl_field == 8'h10, "R10 field position", flags_bl_field, 8'h10);
        cycles(70);                           // R11 interval from this power-up
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #50000;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule